// File: doc/BRIEF.md
# Urgency-Driven Thread Switch Arbiter

This block decides when a two-context, switch-on-event core should hand the pipeline from its foreground thread to its background thread. Each thread carries a 3-bit urgency value. The value rests at 5 while the thread is making normal progress. A blocking event lowers it by one. An external interrupt raises it to 6. A residency timeout raises it to 7. When the foreground thread's urgency falls strictly below the background thread's, the block asks for a switch.

The core drains its pipeline and then answers with an acknowledge. The block then swaps the thread roles and restarts its residency timer. It keeps the request low for one cycle so that the new foreground thread can settle. The residency timer counts foreground cycles up to a limit set on a pin. When it expires, the waiting background thread becomes maximally urgent, so neither thread can hold the pipeline indefinitely.

All pins are plain control signals. Event inputs are one bit per thread, with bit i belonging to thread i, and each is sampled on every rising clock edge. There is no data stream, so there is no back-pressure.

Top module: `urgency_switch_arb`

## Requirements
- R1: While reset is asserted and just after it is released, both urgencies are 5, `fg_id` is 0 and `switch_req` is low.
- R2: A `miss_evt` bit lowers that thread's urgency by one at the next edge. The value saturates at 0 and never wraps.
- R3: A `fill_evt` bit (blocking data returned) sets that thread's urgency to 5.
- R4: An `irq_evt` bit sets that thread's urgency to 6.
- R5: When `tmo_limit` is nonzero, a residency counter advances once per cycle. On the edge after it reaches `tmo_limit`, it restarts from 0 and sets the background thread's urgency to 7. A limit of 0 disables timeouts.
- R6: When several events hit one thread in the same cycle, they take priority in this order: timeout (7), then interrupt (6), then fill (5), then miss (decrement).
- R7: `switch_req` is high exactly when the foreground urgency is strictly lower than the background urgency, except during the hold cycle of R8. Equal urgencies never request a switch.
- R8: `switch_ack` sampled high while `switch_req` is high does three things at that edge: it toggles `fg_id`, it restarts the residency counter, and it forces `switch_req` low for the following cycle.
- R9: `switch_ack` sampled while `switch_req` is low has no effect on `fg_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_limit | input | TMO_W | Residency timeout in cycles; 0 disables it |
| irq_evt | input | 2 | Per-thread external interrupt pulse |
| miss_evt | input | 2 | Per-thread blocking-operation pulse |
| fill_evt | input | 2 | Per-thread blocking-data-returned pulse |
| switch_ack | input | 1 | Core reports that the requested switch has completed |
| switch_req | output | 1 | Request to switch the foreground thread |
| fg_id | output | 1 | Index of the current foreground thread |

## Verification
The comparison is driven with single misses on one thread only and with misses on both threads. This separates the strict less-than rule from a less-or-equal rule. Long runs of misses on one thread tell saturation apart from wrap-around. Simultaneous interrupt-plus-miss and interrupt-plus-fill events each produce a different request level for each possible priority order. The timeout is run disabled, then with a short limit, and then across a switch acknowledge with a miss placed one cycle before expiry. That last pattern shows whether the acknowledge really restarts the counter.

// File: rtl/urg_pkg.sv
package urg_pkg;
  localparam int UW = 3;
  typedef logic [UW-1:0] urg_t;

  localparam urg_t LVL_NOM = 3'd5;
  localparam urg_t LVL_IRQ = 3'd6;
  localparam urg_t LVL_TMO = 3'd7;
  localparam urg_t LVL_MIN = 3'd0;

  typedef struct packed {
    logic tmo;
    logic irq;
    logic fill;
    logic miss;
  } urg_evt_t;

  function automatic urg_t next_lvl(urg_t cur, urg_evt_t ev);
    urg_t nxt;
    if (ev.tmo)       nxt = LVL_TMO;
    else if (ev.irq)  nxt = LVL_IRQ;
    else if (ev.fill) nxt = LVL_NOM;
    else if (ev.miss) nxt = (cur == LVL_MIN) ? LVL_MIN : urg_t'(cur - 1'b1);
    else              nxt = cur;
    return nxt;
  endfunction
endpackage

// File: rtl/urg_level_reg.sv
module urg_level_reg
  import urg_pkg::*;
#(
  parameter urg_t RST_LVL = LVL_NOM
) (
  input  logic     clk,
  input  logic     rst_n,
  input  urg_evt_t ev_i,
  output urg_t     lvl_o
);
  urg_t lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= RST_LVL;
    else        lvl_q <= next_lvl(lvl_q, ev_i);
  end

  assign lvl_o = lvl_q;

  // R2
  dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == '{tmo:1'b0, irq:1'b0, fill:1'b0, miss:1'b1} && lvl_q != LVL_MIN)
      |=> lvl_q == urg_t'($past(lvl_q) - 1'b1));

  // R2
  dec_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i.miss && !ev_i.tmo && !ev_i.irq && !ev_i.fill && lvl_q == LVL_MIN)
      |=> lvl_q == LVL_MIN);

  // R5
  tmo_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.tmo |=> lvl_q == LVL_TMO);

  // R6
  irq_over_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i.irq && !ev_i.tmo) |=> lvl_q == LVL_IRQ);

  // R3
  fill_nom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i.fill && !ev_i.irq && !ev_i.tmo) |=> lvl_q == LVL_NOM);
endmodule

// File: rtl/urg_timeout_ctr.sv
module urg_timeout_ctr #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             enabled;

  assign enabled  = (limit_i != '0);
  assign expire_o = enabled && (cnt_q >= limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               cnt_q <= '0;
    else if (restart_i || expire_o || !enabled) cnt_q <= '0;
    else                                      cnt_q <= cnt_q + 1'b1;
  end

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> cnt_q == '0);

  // R5
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && !restart_i && !expire_o) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R5
  expire_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> cnt_q == '0);
endmodule

// File: rtl/urg_switch_ctl.sv
module urg_switch_ctl
  import urg_pkg::*;
#(
  parameter int TID_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  urg_t             fg_lvl_i,
  input  urg_t             bg_lvl_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic             swap_o,
  output logic [TID_W-1:0] fg_id_o
);
  logic             hold_q;
  logic [TID_W-1:0] fg_q;

  assign req_o  = !hold_q && (fg_lvl_i < bg_lvl_i);
  assign swap_o = ack_i && req_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      fg_q   <= '0;
    end else begin
      hold_q <= swap_o;
      if (swap_o) fg_q <= fg_q + 1'b1;
    end
  end

  assign fg_id_o = fg_q;

  // R8
  swap_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && req_o) |=> (fg_id_o != $past(fg_id_o)) && !req_o);

  // R9
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !req_o) |=> $stable(fg_id_o));

  // R7
  no_req_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fg_lvl_i >= bg_lvl_i) |-> !req_o);
endmodule

// File: rtl/urgency_switch_arb.sv
module urgency_switch_arb
  import urg_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic [1:0]       irq_evt,
  input  logic [1:0]       miss_evt,
  input  logic [1:0]       fill_evt,
  input  logic             switch_ack,
  output logic             switch_req,
  output logic             fg_id
);
  localparam int NUM_THR = 2;
  localparam int TID_W   = $clog2(NUM_THR);

  logic [TID_W-1:0] fg_sel;
  logic [TID_W-1:0] bg_sel;
  logic             expire;
  logic             swap;
  urg_t             lvl   [NUM_THR];
  urg_evt_t         evt   [NUM_THR];

  assign bg_sel = fg_sel + 1'b1;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign evt[t] = '{tmo:  expire && (bg_sel == TID_W'(t)),
                      irq:  irq_evt[t],
                      fill: fill_evt[t],
                      miss: miss_evt[t]};

    urg_level_reg #(.RST_LVL(LVL_NOM)) u_lvl (
      .clk   (clk),
      .rst_n (rst_n),
      .ev_i  (evt[t]),
      .lvl_o (lvl[t])
    );
  end

  urg_timeout_ctr #(.TMO_W(TMO_W)) u_tmo (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (swap),
    .limit_i   (tmo_limit),
    .expire_o  (expire)
  );

  urg_switch_ctl #(.TID_W(TID_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fg_lvl_i (lvl[fg_sel]),
    .bg_lvl_i (lvl[bg_sel]),
    .ack_i    (switch_ack),
    .req_o    (switch_req),
    .swap_o   (swap),
    .fg_id_o  (fg_sel)
  );

  assign fg_id = fg_sel;
endmodule

// File: tb/urgency_switch_arb_tb.sv
module urgency_switch_arb_tb;
  localparam int TMO_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [TMO_W-1:0] tmo_limit = '0;
  logic [1:0]       irq_evt = '0, miss_evt = '0, fill_evt = '0;
  logic             switch_ack = 1'b0;
  logic             switch_req;
  logic             fg_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  urgency_switch_arb #(.TMO_W(TMO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
    .irq_evt(irq_evt), .miss_evt(miss_evt), .fill_evt(fill_evt),
    .switch_ack(switch_ack), .switch_req(switch_req), .fg_id(fg_id)
  );

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  // Inputs held across one rising edge, outputs sampled 5 ns after it.
  task automatic step(input logic [1:0] irq, input logic [1:0] miss,
                      input logic [1:0] fill, input logic ack);
    irq_evt = irq; miss_evt = miss; fill_evt = fill; switch_ack = ack;
    @(posedge clk); #5;
    irq_evt = '0; miss_evt = '0; fill_evt = '0; switch_ack = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tmo_limit = '0;
    @(posedge clk); #5;
    rst_n = 1'b1;
    @(posedge clk); #5;
  endtask

  task automatic t_reset();
    do_reset();
    check(switch_req, 1'b0, "R1 req after reset");
    check(fg_id, 1'b0, "R1 fg after reset");
  endtask

  task automatic t_decrement();
    do_reset();
    step(2'b00, 2'b01, 2'b00, 1'b0);
    check(switch_req, 1'b1, "R2/R7 fg 4 vs bg 5");
    step(2'b00, 2'b10, 2'b00, 1'b0);
    check(switch_req, 1'b0, "R7 equal 4 vs 4");
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 7; i++) step(2'b00, 2'b01, 2'b00, 1'b0);
    check(switch_req, 1'b1, "R2 floor 0 below 5");
    for (int i = 0; i < 5; i++) step(2'b00, 2'b10, 2'b00, 1'b0);
    check(switch_req, 1'b0, "R2 both at floor");
  endtask

  task automatic t_fill();
    do_reset();
    step(2'b00, 2'b01, 2'b00, 1'b0);
    step(2'b00, 2'b01, 2'b00, 1'b0);
    check(switch_req, 1'b1, "R3 pre-fill 3 vs 5");
    step(2'b00, 2'b00, 2'b01, 1'b0);
    check(switch_req, 1'b0, "R3 fill back to 5");
  endtask

  task automatic t_irq();
    do_reset();
    step(2'b10, 2'b00, 2'b00, 1'b0);
    check(switch_req, 1'b1, "R4 bg irq to 6");
    do_reset();
    step(2'b01, 2'b01, 2'b00, 1'b0);
    check(switch_req, 1'b0, "R6 irq beats miss on fg");
    do_reset();
    step(2'b10, 2'b00, 2'b10, 1'b0);
    check(switch_req, 1'b1, "R6 irq beats fill on bg");
  endtask

  task automatic t_hold();
    do_reset();
    step(2'b00, 2'b01, 2'b00, 1'b0);
    step(2'b01, 2'b00, 2'b00, 1'b1);
    check(fg_id, 1'b1, "R8 fg toggles on ack");
    check(switch_req, 1'b0, "R8 hold cycle");
    step(2'b00, 2'b00, 2'b00, 1'b0);
    check(switch_req, 1'b1, "R8 request after hold");
  endtask

  task automatic t_stray_ack();
    do_reset();
    step(2'b00, 2'b00, 2'b00, 1'b1);
    check(fg_id, 1'b0, "R9 stray ack ignored");
    step(2'b00, 2'b01, 2'b00, 1'b0);
    check(switch_req, 1'b1, "R9 no hold after stray ack");
  endtask

  task automatic t_timeout();
    do_reset();
    for (int i = 0; i < 20; i++) step(2'b00, 2'b00, 2'b00, 1'b0);
    check(switch_req, 1'b0, "R5 limit 0 disables");
    tmo_limit = 16'd4;
    for (int i = 0; i < 4; i++) step(2'b00, 2'b00, 2'b00, 1'b0);
    check(switch_req, 1'b0, "R5 before expiry");
    step(2'b00, 2'b00, 2'b00, 1'b0);
    check(switch_req, 1'b1, "R5 bg urgent at expiry");
    step(2'b00, 2'b00, 2'b00, 1'b1);
    check(fg_id, 1'b1, "R8 swap after timeout");
    for (int i = 0; i < 3; i++) step(2'b00, 2'b00, 2'b00, 1'b0);
    step(2'b00, 2'b10, 2'b00, 1'b0);
    check(switch_req, 1'b0, "R8 counter restarted by ack");
    step(2'b00, 2'b00, 2'b00, 1'b0);
    check(switch_req, 1'b1, "R5 second expiry raises thread0");
    tmo_limit = '0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_decrement();
    t_saturate();
    t_fill();
    t_irq();
    t_hold();
    t_stray_ack();
    t_timeout();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule